// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block turns a READ or WRITE command's start column into the column address of every data beat in a double-data-rate SDRAM burst. The burst length and beat order come from a mode-register-set write. Each command starts a burst. The block then presents two beat addresses per clock, one for the rising-edge beat and one for the falling-edge beat, until the burst is done.

All beats stay inside a column block aligned to the burst length. The beat order inside that block is either a wrapping upward count or a XOR of the start column with the beat index. A later command may cut a running burst short, or follow straight on from it. In both cases generation restarts from the new column.

The block sits between a command decoder and the data-path sequencer. It supplies the address stream together with a valid flag and a final-pair flag. The column width is a parameter: 9 bits for x32 parts, 10 bits for x16 and 11 bits for x8.

Top module: `ddr_beat_colgen`

## Requirements
- R1: A mode write (`mrs_valid` high with `mrs_bank` = 00) sets the burst length from `mrs_blen`: 3'b001 gives 2 beats, 3'b010 gives 4 and 3'b011 gives 8. It sets the order from `mrs_ilv`: 0 is sequential, 1 is interleaved.
- R2: A mode write is ignored when `mrs_bank` is not 00, or when `mrs_blen` holds any other code. The previously held length and order stay in effect.
- R3: In sequential order, the low log2(BL) bits of beat i are (start + i) mod BL.
- R4: In interleaved order, the low log2(BL) bits of beat i are start XOR i.
- R5: For every beat, the column bits above the low log2(BL) bits equal those of the start column, so a burst never leaves its aligned block.
- R6: Beats 2k and 2k+1 appear together on `beat_col_even` and `beat_col_odd`. The first pair is valid in the cycle after the clock edge that samples `cmd_valid`.
- R7: A burst occupies BL/2 consecutive valid cycles. `beat_last` is high only in the cycle of the final pair. `beat_valid` is low in the following cycle unless a new command arrived.
- R8: A command sampled while a burst is running ends that burst. The next cycle carries beats 0 and 1 of the new start column, and a full new burst follows.
- R9: A burst keeps the length and order in effect at its command edge. A mode write made during the burst affects only later commands.
- R10: After reset, `beat_valid` and `beat_last` are low, and the mode is 4 beats in sequential order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_valid | input | 1 | Mode-register write strobe |
| mrs_bank | input | 2 | Bank bits of the mode write; 00 selects this register |
| mrs_blen | input | 3 | Burst length code |
| mrs_ilv | input | 1 | Beat order: 0 sequential, 1 interleaved |
| cmd_valid | input | 1 | READ or WRITE command strobe |
| cmd_col | input | COL_W | Start column of the command |
| beat_valid | output | 1 | A beat pair is presented this cycle |
| beat_col_even | output | COL_W | Column of the rising-edge beat (beat 2k) |
| beat_col_odd | output | COL_W | Column of the falling-edge beat (beat 2k+1) |
| beat_last | output | 1 | This pair ends the burst |

## Verification
The hardest case to reach from the ports is a change arriving in the middle of a burst. This covers a command that cuts an 8-beat burst after its second pair, and a mode write that lands while an interleaved burst is still running. The bench drives both on the falling edge right after a checked pair. It then compares every later pair against the burst's own start column and captured mode. Finally it checks that the next command picks up the new mode.

// File: rtl/ddr_colgen_pkg.sv
package ddr_colgen_pkg;

  // Burst length codes carried on the mode write
  typedef enum logic [2:0] {
    BLEN_2 = 3'b001,
    BLEN_4 = 3'b010,
    BLEN_8 = 3'b011
  } blen_e;

  localparam int IDX_W  = 3;            // beat index width for up to 8 beats
  localparam int PAIR_W = IDX_W - 1;    // pair index width
  localparam int LANES  = 2;            // beats per clock

  // Mask of the wrapping low column bits for a burst length
  function automatic logic [IDX_W-1:0] blen_mask(blen_e b);
    case (b)
      BLEN_2:  return 3'b001;
      BLEN_8:  return 3'b111;
      default: return 3'b011;
    endcase
  endfunction

endpackage

// File: rtl/ddr_mode_latch.sv
module ddr_mode_latch
  import ddr_colgen_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrs_valid,
  input  logic [BANK_W-1:0] mrs_bank,
  input  logic [2:0]        mrs_blen,
  input  logic              mrs_ilv,
  output logic [IDX_W-1:0]  mode_mask,
  output logic              mode_ilv
);

  blen_e blen_q;
  logic  code_ok;
  logic  take;

  assign code_ok = (mrs_blen == BLEN_2) || (mrs_blen == BLEN_4) || (mrs_blen == BLEN_8);
  assign take    = mrs_valid && (mrs_bank == '0) && code_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      blen_q   <= BLEN_4;
      mode_ilv <= 1'b0;
    end else if (take) begin
      blen_q   <= blen_e'(mrs_blen);
      mode_ilv <= mrs_ilv;
    end
  end

  assign mode_mask = blen_mask(blen_q);

endmodule

// File: rtl/ddr_beat_order.sv
module ddr_beat_order
  import ddr_colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0]            start_col,
  input  logic [IDX_W-1:0]            wrap_mask,
  input  logic                        ilv,
  input  logic [IDX_W-1:0]            base_idx,
  output logic [LANES-1:0][COL_W-1:0] lane_col
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] low;
    logic [IDX_W-1:0] merged;

    assign idx    = base_idx + IDX_W'(k);
    assign low    = ilv ? (start_col[IDX_W-1:0] ^ idx)
                        : (start_col[IDX_W-1:0] + idx);
    assign merged = (start_col[IDX_W-1:0] & ~wrap_mask) | (low & wrap_mask);
    assign lane_col[k] = {start_col[COL_W-1:IDX_W], merged};
  end

endmodule

// File: rtl/ddr_beat_seq.sv
module ddr_beat_seq
  import ddr_colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [IDX_W-1:0] mode_mask,
  input  logic             mode_ilv,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col_even,
  output logic [COL_W-1:0] beat_col_odd,
  output logic             beat_last
);

  logic              act_q;
  logic [COL_W-1:0]  start_q;
  logic [IDX_W-1:0]  mask_q;
  logic              ilv_q;
  logic [PAIR_W-1:0] pair_q;

  logic [PAIR_W-1:0] nxt_pair;
  logic [COL_W-1:0]  sel_start;
  logic [IDX_W-1:0]  sel_mask;
  logic              sel_ilv;
  logic [IDX_W-1:0]  sel_base;
  logic              sel_last;
  logic [LANES-1:0][COL_W-1:0] lane_col;

  assign nxt_pair  = pair_q + 1'b1;
  assign sel_start = cmd_valid ? cmd_col   : start_q;
  assign sel_mask  = cmd_valid ? mode_mask : mask_q;
  assign sel_ilv   = cmd_valid ? mode_ilv  : ilv_q;
  assign sel_base  = cmd_valid ? '0 : {nxt_pair, 1'b0};
  // final pair index equals the upper mask bits (0, 1 or 3)
  assign sel_last  = cmd_valid ? (mode_mask[IDX_W-1:1] == '0)
                               : (nxt_pair == mask_q[IDX_W-1:1]);

  ddr_beat_order #(.COL_W(COL_W)) u_order (
    .start_col (sel_start),
    .wrap_mask (sel_mask),
    .ilv       (sel_ilv),
    .base_idx  (sel_base),
    .lane_col  (lane_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q         <= 1'b0;
      start_q       <= '0;
      mask_q        <= '0;
      ilv_q         <= 1'b0;
      pair_q        <= '0;
      beat_valid    <= 1'b0;
      beat_last     <= 1'b0;
      beat_col_even <= '0;
      beat_col_odd  <= '0;
    end else if (cmd_valid) begin
      start_q       <= cmd_col;
      mask_q        <= mode_mask;
      ilv_q         <= mode_ilv;
      pair_q        <= '0;
      act_q         <= !sel_last;
      beat_valid    <= 1'b1;
      beat_last     <= sel_last;
      beat_col_even <= lane_col[0];
      beat_col_odd  <= lane_col[1];
    end else if (act_q) begin
      pair_q        <= nxt_pair;
      act_q         <= !sel_last;
      beat_valid    <= 1'b1;
      beat_last     <= sel_last;
      beat_col_even <= lane_col[0];
      beat_col_odd  <= lane_col[1];
    end else begin
      beat_valid    <= 1'b0;
      beat_last     <= 1'b0;
    end
  end

endmodule

// File: rtl/ddr_beat_colgen.sv
module ddr_beat_colgen
  import ddr_colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mrs_valid,
  input  logic [1:0]       mrs_bank,
  input  logic [2:0]       mrs_blen,
  input  logic             mrs_ilv,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col_even,
  output logic [COL_W-1:0] beat_col_odd,
  output logic             beat_last
);

  logic [IDX_W-1:0] mode_mask;
  logic             mode_ilv;

  ddr_mode_latch #(.BANK_W(2)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .mrs_valid (mrs_valid),
    .mrs_bank  (mrs_bank),
    .mrs_blen  (mrs_blen),
    .mrs_ilv   (mrs_ilv),
    .mode_mask (mode_mask),
    .mode_ilv  (mode_ilv)
  );

  ddr_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_col       (cmd_col),
    .mode_mask     (mode_mask),
    .mode_ilv      (mode_ilv),
    .beat_valid    (beat_valid),
    .beat_col_even (beat_col_even),
    .beat_col_odd  (beat_col_odd),
    .beat_last     (beat_last)
  );

endmodule

// File: rtl/ddr_beat_colgen_chk.sv
module ddr_beat_colgen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [COL_W-1:0] cmd_col,
  input logic             beat_valid,
  input logic [COL_W-1:0] beat_col_even,
  input logic [COL_W-1:0] beat_col_odd,
  input logic             beat_last
);

  AST_CMD_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> beat_valid && (beat_col_even == $past(cmd_col))); // R8

  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid); // R7

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (beat_last && !cmd_valid) |=> !beat_valid); // R7

  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last) |=> beat_valid); // R7

  AST_PAIR_SAME_BLOCK: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_col_even[COL_W-1:3] == beat_col_odd[COL_W-1:3])); // R5

  AST_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_col_even != beat_col_odd)); // R6

endmodule

bind ddr_beat_colgen ddr_beat_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_col       (cmd_col),
  .beat_valid    (beat_valid),
  .beat_col_even (beat_col_even),
  .beat_col_odd  (beat_col_odd),
  .beat_last     (beat_last)
);

// File: tb/ddr_beat_colgen_tb.sv
module ddr_beat_colgen_tb;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mrs_valid = 1'b0;
  logic [1:0]       mrs_bank = 2'b00;
  logic [2:0]       mrs_blen = 3'b000;
  logic             mrs_ilv = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic             beat_valid;
  logic [COL_W-1:0] beat_col_even;
  logic [COL_W-1:0] beat_col_odd;
  logic             beat_last;

  int nvec = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  ddr_beat_colgen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst(rst), .mrs_valid(mrs_valid), .mrs_bank(mrs_bank),
    .mrs_blen(mrs_blen), .mrs_ilv(mrs_ilv), .cmd_valid(cmd_valid),
    .cmd_col(cmd_col), .beat_valid(beat_valid), .beat_col_even(beat_col_even),
    .beat_col_odd(beat_col_odd), .beat_last(beat_last)
  );

  typedef struct packed {
    logic [2:0]       code;
    logic             ilv;
    logic [COL_W-1:0] col;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'b001, 1'b0, 10'h2A5},
    '{3'b001, 1'b1, 10'h2A4},
    '{3'b010, 1'b0, 10'h13E},
    '{3'b010, 1'b1, 10'h0F7},
    '{3'b011, 1'b0, 10'h3FD},
    '{3'b011, 1'b1, 10'h155},
    '{3'b011, 1'b0, 10'h008},
    '{3'b010, 1'b1, 10'h3FF}
  };

  function automatic int code_len(logic [2:0] c);
    return (c == 3'b001) ? 2 : (c == 3'b011) ? 8 : 4;
  endfunction

  // Expected beat column from R3, R4 and R5
  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int bl, logic il, int i);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] low;
    m   = COL_W'(bl - 1);
    low = il ? (s ^ COL_W'(i)) : (s + COL_W'(i));
    return (s & ~m) | (low & m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_mrs(input logic [1:0] bank, input logic [2:0] code, input logic il);
    @(negedge clk);
    mrs_valid = 1'b1; mrs_bank = bank; mrs_blen = code; mrs_ilv = il;
    @(negedge clk);
    mrs_valid = 1'b0; mrs_bank = 2'b00;
  endtask

  task automatic start_cmd(input logic [COL_W-1:0] col);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = col;
    @(posedge clk); #1;
  endtask

  // First pair is already sampled on entry; ends at a falling edge with strobes low
  task automatic walk(input logic [COL_W-1:0] s, input int bl, input logic il,
                      input int pfirst, input int plast, input string req);
    for (int p = pfirst; p <= plast; p++) begin
      if (p != pfirst) begin
        @(posedge clk); #1;
      end
      chk({req, " valid"}, 32'(beat_valid), 32'd1);
      chk({req, " even"},  32'(beat_col_even), 32'(exp_col(s, bl, il, 2*p)));
      chk({req, " odd"},   32'(beat_col_odd),  32'(exp_col(s, bl, il, 2*p+1)));
      chk({req, " last"},  32'(beat_last), 32'(p == bl/2 - 1));
      @(negedge clk);
      cmd_valid = 1'b0; mrs_valid = 1'b0;
    end
  endtask

  task automatic chk_idle(input string req);
    @(posedge clk); #1;
    chk({req, " idle valid"}, 32'(beat_valid), 32'd0);
    chk({req, " idle last"},  32'(beat_last), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 reset valid", 32'(beat_valid), 32'd0);
    chk("R10 reset last",  32'(beat_last), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    // R10: default mode is 4 beats sequential
    start_cmd(10'h1C6);
    walk(10'h1C6, 4, 1'b0, 0, 1, "R10 default mode");
    chk_idle("R10 default");

    // Table: R1 R3 R4 R5 R6 R7 across lengths and orders
    for (int v = 0; v < NV; v++) begin
      do_mrs(2'b00, VEC[v].code, VEC[v].ilv);
      start_cmd(VEC[v].col);
      walk(VEC[v].col, code_len(VEC[v].code), VEC[v].ilv, 0,
           code_len(VEC[v].code)/2 - 1, VEC[v].ilv ? "R1 R4 R5 R6" : "R1 R3 R5 R6");
      chk_idle("R7");
    end

    // R2: writes to another bank and illegal codes are ignored
    do_mrs(2'b00, 3'b010, 1'b0);
    do_mrs(2'b01, 3'b011, 1'b1);
    do_mrs(2'b00, 3'b111, 1'b1);
    start_cmd(10'h20B);
    walk(10'h20B, 4, 1'b0, 0, 1, "R2 ignored mode write");
    chk_idle("R2");

    // R8: truncate an 8-beat burst after two pairs
    do_mrs(2'b00, 3'b011, 1'b0);
    start_cmd(10'h0A3);
    walk(10'h0A3, 8, 1'b0, 0, 1, "R8 first burst");
    cmd_valid = 1'b1; cmd_col = 10'h37E;
    @(posedge clk); #1;
    walk(10'h37E, 8, 1'b0, 0, 3, "R8 restarted burst");
    chk_idle("R8");

    // R9: mode write during a running burst affects only later commands
    do_mrs(2'b00, 3'b011, 1'b1);
    start_cmd(10'h2C9);
    walk(10'h2C9, 8, 1'b1, 0, 0, "R9 running burst");
    mrs_valid = 1'b1; mrs_bank = 2'b00; mrs_blen = 3'b001; mrs_ilv = 1'b0;
    @(posedge clk); #1;
    walk(10'h2C9, 8, 1'b1, 1, 3, "R9 running burst");
    chk_idle("R9");
    start_cmd(10'h155);
    walk(10'h155, 2, 1'b0, 0, 0, "R9 next burst");
    chk_idle("R9 next");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule